// File: doc/BRIEF.md
# Page-Wrapping Address Counter and Write Buffer

This unit sits behind a serial-bus slave controller of a byte-organized non-volatile memory. It holds the word-address counter, gathers incoming data bytes into a one-page staging buffer, and copies the staged bytes into a behavioural storage array when the controller issues a commit. It then reports busy for a fixed write-cycle time, counted in system clocks. On reads it returns the byte at the counter and advances the counter.

The controller drives single-cycle strobes to the unit: load the high or the low address byte, write a data byte, read a data byte, and commit. Writes advance only the in-page part of the address, so a long burst wraps around inside one page and overwrites its own earlier bytes. Reads advance the full address and wrap from the top of the array to address 0. Only buffer entries written since the last address load or commit are copied. The full 64 KB arrangement with 512 pages of 128 bytes uses ADDR_W=16 and PAGE_W=7. The default build is smaller and keeps the same 128-byte page.

Top module: `page_wrap_wbuf`

## Requirements
- R1: After reset the address counter is 0, busy_o is 0, rd_data_o is 0, and no buffer entry is marked written.
- R2: A load-high strobe sets the address bits above bit 7 from din_i. A load-low strobe sets address bits 7..0 from din_i. The other address bits are kept.
- R3: A write strobe stores din_i at buffer position addr[PAGE_W-1:0] and marks that entry written. It then increments the low PAGE_W address bits modulo the page size and leaves the upper bits unchanged.
- R4: A burst longer than one page wraps to the start of the same page. A position written more than once commits the last value written.
- R5: A commit copies only the marked buffer entries into the page selected by the upper address bits. All other bytes of the array keep their contents.
- R6: busy_o rises in the cycle after an accepted commit and stays high for exactly WRITE_CYCLES cycles.
- R7: While busy_o is high, every strobe is ignored. The address, the buffer, rd_data_o and the busy length do not change.
- R8: A read strobe puts the array byte at the current address on rd_data_o in the following cycle and holds it there until the next read. The address then increments across the full width.
- R9: A read at the last array address is followed by address 0.
- R10: After a write burst and its commit, a current-address read returns the byte after the last position written, wrapped within the page.
- R11: Every address load and every completed commit unmarks all buffer entries. Bytes written before a reload are never committed.
- R12: At most one strobe is high in any cycle. The controller guarantees this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_hi_i | input | 1 | Load upper address byte from din_i |
| ld_lo_i | input | 1 | Load lower address byte from din_i |
| wr_i | input | 1 | Stage din_i as a data byte |
| rd_i | input | 1 | Read the byte at the address counter |
| commit_i | input | 1 | Copy staged bytes to the array and start the write cycle |
| din_i | input | 8 | Address or data byte |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The assertions check several rules on every cycle: how the address steps on writes and reads, that idle cycles leave the address alone, the exact busy length, that the array is only written while busy, that the written-marks are empty after each clear, and that the strobes are mutually exclusive. The bench's scenarios are needed to show the stored data itself. They cover a full array sweep, the in-page overwrite on long bursts, the preservation of unwritten bytes on partial commits, the discarding of staged bytes on reload, and strobes issued during busy that leave no trace.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LD_HI,
    OP_LD_LO,
    OP_WR,
    OP_RD,
    OP_COMMIT
  } pwb_op_e;

  // Busy blocks every strobe; otherwise a fixed priority picks one.
  function automatic pwb_op_e pwb_decode(input logic busy, input logic ld_hi,
                                         input logic ld_lo, input logic wr,
                                         input logic rd, input logic cm);
    if (busy)       return OP_NONE;
    else if (cm)    return OP_COMMIT;
    else if (wr)    return OP_WR;
    else if (rd)    return OP_RD;
    else if (ld_lo) return OP_LD_LO;
    else if (ld_hi) return OP_LD_HI;
    else            return OP_NONE;
  endfunction

endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  pwb_op_e           op_i,
  input  logic [7:0]        din_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   hi_byte;

  assign hi_byte = din_i[HI_W-1:0];

  generate
    if (HI_W < 8) begin : g_hi_trim
      logic hi_spare;
      assign hi_spare = ^din_i[7:HI_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      case (op_i)
        OP_LD_HI: addr_q[ADDR_W-1:8] <= hi_byte;
        OP_LD_LO: addr_q[7:0] <= din_i;
        OP_WR:    addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
        OP_RD:    addr_q <= addr_q + 1'b1;
        default:  addr_q <= addr_q;
      endcase
    end
  end

  assign addr_o = addr_q;

  assert_wr_in_page_R3: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_WR |=>
      (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])) &&
      (addr_q[PAGE_W-1:0] == PAGE_W'($past(addr_q[PAGE_W-1:0]) + 1'b1)));

  assert_rd_full_step_R8: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_RD |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_NONE |=> $stable(addr_q));

  assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_LD_LO |=> $stable(addr_q[ADDR_W-1:8]));

endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0]        buf_mem [PAGE_N];
  logic [PAGE_N-1:0] mark_q;
  logic [7:0]        rd_data_q;
  logic              rd_vld_q;

  // Data storage without reset so it maps onto a RAM.
  always_ff @(posedge clk) begin
    if (wr_en_i) buf_mem[wr_idx_i] <= wr_data_i;
    rd_data_q <= buf_mem[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q   <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= mark_q[rd_idx_i];
      if (clr_i)        mark_q <= '0;
      else if (wr_en_i) mark_q[wr_idx_i] <= 1'b1;
    end
  end

  assign rd_data_o = rd_data_q;
  assign rd_vld_o  = rd_vld_q;

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> mark_q == '0);

  assert_write_marks_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !clr_i) |=> mark_q[$past(wr_idx_i)]);

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int PAGE_W       = 7,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              buf_vld_i,
  output logic              busy_o,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic              mem_we_o,
  output logic [PAGE_W-1:0] mem_idx_o,
  output logic              clr_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_PAGE  = CNT_W'(PAGE_N);
  localparam logic [CNT_W-1:0] CNT_CLEAR = CNT_W'(PAGE_N + 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(WRITE_CYCLES);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              stage_q;
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      stage_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      stage_q <= busy_q && (cnt_q < CNT_PAGE);
      idx_q   <= cnt_q[PAGE_W-1:0];
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else begin
        if (cnt_q == CNT_LAST) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign buf_idx_o = cnt_q[PAGE_W-1:0];
  assign mem_we_o  = stage_q && buf_vld_i;
  assign mem_idx_o = idx_q;
  assign clr_o     = busy_q && (cnt_q == CNT_CLEAR);

  // Independent run-length counter for the busy window check.
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !busy_q) run_q <= '0;
    else                run_q <= run_q + 1'b1;
  end

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> run_q == CNT_FULL);

  assert_busy_starts_R6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> busy_q);

  assert_array_write_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_q);

endmodule

// File: rtl/pwb_mem_array.sv
module pwb_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

  assert_no_port_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !(we_i && re_i));

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !re_i |=> $stable(rdata_q));

endmodule

// File: rtl/page_wrap_wbuf.sv
module page_wrap_wbuf
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 7,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_hi_i,
  input  logic       ld_lo_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       commit_i,
  input  logic [7:0] din_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o
);
  localparam int PAGE_HI_W = ADDR_W - PAGE_W;

  pwb_op_e           op;
  logic [ADDR_W-1:0] addr;
  logic              busy;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0]        buf_data;
  logic              buf_vld;
  logic              mem_we;
  logic [PAGE_W-1:0] mem_idx;
  logic              seq_clr;
  logic              mark_clr;
  logic [ADDR_W-1:0] mem_waddr;

  assign op        = pwb_decode(busy, ld_hi_i, ld_lo_i, wr_i, rd_i, commit_i);
  assign mark_clr  = seq_clr || (op == OP_LD_HI) || (op == OP_LD_LO);
  assign mem_waddr = {addr[ADDR_W-1:PAGE_W], mem_idx};

  pwb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op),
    .din_i  (din_i),
    .addr_o (addr)
  );

  pwb_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (op == OP_WR),
    .wr_idx_i  (addr[PAGE_W-1:0]),
    .wr_data_i (din_i),
    .clr_i     (mark_clr),
    .rd_idx_i  (buf_idx),
    .rd_data_o (buf_data),
    .rd_vld_o  (buf_vld)
  );

  pwb_commit_seq #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (op == OP_COMMIT),
    .buf_vld_i (buf_vld),
    .busy_o    (busy),
    .buf_idx_o (buf_idx),
    .mem_we_o  (mem_we),
    .mem_idx_o (mem_idx),
    .clr_o     (seq_clr)
  );

  pwb_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (buf_data),
    .re_i    (op == OP_RD),
    .raddr_i (addr),
    .rdata_o (rd_data_o)
  );

  assign busy_o = busy;

  assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_hi_i, ld_lo_i, wr_i, rd_i, commit_i}));

  assert_page_frozen_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr[ADDR_W-1:ADDR_W-PAGE_HI_W]));

endmodule

// File: tb/page_wrap_wbuf_tb.sv
module page_wrap_wbuf_tb_top;
  localparam int AW = 9;
  localparam int PW = 4;
  localparam int WC = 24;
  localparam int PS = 1 << PW;
  localparam int MS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_hi = 0, ld_lo = 0, wr = 0, rd = 0, cm = 0;
  logic [7:0] din = '0;
  logic [7:0] rd_data;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  int ref_mem [MS];
  int ref_buf [PS];
  bit ref_mark [PS];
  int ref_addr = 0;

  always #4 clk = ~clk;

  page_wrap_wbuf #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst(rst), .ld_hi_i(ld_hi), .ld_lo_i(ld_lo), .wr_i(wr),
    .rd_i(rd), .commit_i(cm), .din_i(din), .rd_data_o(rd_data), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  task automatic clr_marks();
    for (int i = 0; i < PS; i++) ref_mark[i] = 0;
  endtask

  task automatic load_addr(input int a);
    ld_hi = 1; din = 8'((a >> 8) & 8'hff);
    @(negedge clk); ld_hi = 0; ld_lo = 1; din = 8'(a & 8'hff);
    @(negedge clk); ld_lo = 0;
    ref_addr = a % MS;
    clr_marks();
  endtask

  task automatic wr_byte(input int d);
    wr = 1; din = 8'(d);
    @(negedge clk); wr = 0;
    ref_buf[ref_addr % PS] = d & 8'hff;
    ref_mark[ref_addr % PS] = 1;
    ref_addr = (ref_addr / PS) * PS + ((ref_addr + 1) % PS);
  endtask

  task automatic rd_check(input string req);
    rd = 1;
    @(negedge clk); rd = 0;
    chk(req, int'(rd_data), ref_mem[ref_addr]);
    ref_addr = (ref_addr + 1) % MS;
  endtask

  task automatic commit(input string req, input bit inject);
    int n;
    int held;
    held = int'(rd_data);
    cm = 1;
    @(negedge clk); cm = 0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (inject) begin
        case (n)
          2: begin ld_lo = 1; din = 8'h55; end
          3: begin ld_lo = 0; wr = 1; din = 8'h5a; end
          4: begin wr = 0; rd = 1; end
          5: begin rd = 0; cm = 1; end
          6: cm = 0;
          7: begin ld_hi = 1; din = 8'h01; end
          8: ld_hi = 0;
          default: ;
        endcase
      end
      @(negedge clk);
    end
    chk(req, n, WC);
    if (inject) chk("R7 read data held during busy", int'(rd_data), held);
    for (int i = 0; i < PS; i++)
      if (ref_mark[i]) ref_mem[(ref_addr / PS) * PS + i] = ref_buf[i];
    clr_marks();
  endtask

  task automatic read_page(input int p, input string req);
    load_addr(p * PS);
    for (int i = 0; i < PS; i++) rd_check(req);
  endtask

  initial begin
    for (int i = 0; i < MS; i++) ref_mem[i] = 0;
    clr_marks();
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 read data after reset", int'(rd_data), 0);

    // Fill every page; page 0 relies on the reset address of 0 (R1).
    for (int p = 0; p < MS / PS; p++) begin
      if (p > 0) load_addr(p * PS);
      for (int i = 0; i < PS; i++) wr_byte((p * PS + i) * 7 + 3);
      commit("R6 busy length", 0);
    end

    // Full sweep with wrap past the top of the array.
    load_addr(0);
    for (int a = 0; a < MS; a++) rd_check(a == MS - 1 ? "R9 last address" : "R8 R1 sweep read");
    rd_check("R9 wrap to address 0");

    // Long burst wrapping inside page 5.
    load_addr(5 * PS + 14);
    for (int i = 0; i < PS + 4; i++) wr_byte(8'h80 + i);
    commit("R6 busy length", 0);
    rd_check("R10 address after wrapped burst");
    read_page(5, "R4 in-page overwrite");

    // Partial page on page 7 (also exercises R3 placement and R2 loading).
    load_addr(7 * PS + 3);
    for (int i = 0; i < 4; i++) wr_byte(8'hc0 + i);
    commit("R6 busy length", 0);
    rd_check("R10 current address read after commit");
    read_page(7, "R5 R3 partial commit");

    // Staged bytes discarded by reload.
    load_addr(9 * PS);
    for (int i = 0; i < 3; i++) wr_byte(8'hee);
    load_addr(9 * PS);
    commit("R11 empty commit length", 0);
    read_page(9, "R11 reload discards staged bytes");

    // Strobes during busy are ignored.
    load_addr(11 * PS + 2);
    wr_byte(8'h11);
    wr_byte(8'h22);
    rd = 0;
    commit("R7 busy length with strobes", 1);
    rd_check("R7 address unchanged by busy strobes");
    commit("R7 empty commit after busy strobes", 0);
    read_page(11, "R7 array after busy strobes");

    // Upper-address loading on the high page half (R2).
    load_addr(MS - PS + 5);
    rd_check("R2 high address byte load");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule